// File: doc/BRIEF.md
# Four-Channel Edge-Select Capture Unit

This block takes a snapshot of a free-running timer value whenever a chosen transition appears on one of four asynchronous capture pins. Each channel has its own 16-bit capture register and its own sticky event flag. Software uses the flags as interrupt requests and reads the captured values to measure the time between external events. A channel whose captured value is never read still works as a plain edge-triggered interrupt input.

Each pin is first synchronised to the clock. Its level is then sampled only on the clock where the machine-cycle phase strobe `phase_i` is high, and the new sample is compared with the one taken one strobe earlier. An edge that matches the channel's mode marks that channel pending. On the next strobe, which is the end of the machine cycle in which the edge was seen, the block loads `timer_i` into the channel register and sets the flag. A flag stays set until software writes a 1 to its clear bit.

Top module: `cap_unit4`

## Requirements
- R1: A pin level is looked at only on strobe clocks. A pulse that comes and goes between two strobes, and so is never seen there, causes no capture and no flag.
- R2: Mode code 01 in a channel's 2-bit field `edge_sel_i[2i+1:2i]` reacts only to a low-to-high change between two consecutive strobe samples.
- R3: Mode code 10 reacts only to a high-to-low change between two consecutive strobe samples.
- R4: Mode code 11 reacts to a change in either direction.
- R5: Mode code 00 disables the channel. Pin changes then leave both its capture register and its flag unchanged.
- R6: A matching edge seen at one strobe loads the `timer_i` value present at the next strobe clock, and the flag is set on that same clock. Neither the register nor the flag changes on any other clock.
- R7: A set flag stays set until a clear is requested.
- R8: If a clear and a new capture fall on the same clock, the capture wins and the flag stays set.
- R9: The channels work independently: an event on one channel changes neither the register nor the flag of any other channel.
- R10: After reset every capture register reads 0 and every flag reads 0.
- R11: A 1 on `flag_clr_i[i]` clears flag i at the next clock edge, on any clock, whether or not it is a strobe clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_i | input | 1 | Machine-cycle phase strobe, high for one clock at the start of each cycle |
| timer_i | input | 16 | Free-running timer value |
| cap_pin_i | input | 4 | Asynchronous capture pins, one per channel |
| edge_sel_i | input | 8 | Per-channel mode, 2 bits each: 00 off, 01 rising, 10 falling, 11 both |
| flag_clr_i | input | 4 | Write-1-to-clear pulses for the flags |
| cap_o | output | 64 | Capture registers; channel i is in bits [16i+15:16i] |
| flag_o | output | 4 | Sticky event flags |

## Verification
The bench builds the block with its default parameters: four channels, a 16-bit timer and a two-stage synchroniser. At this size each channel's mode field and each capture register's position in the flat output bus are checked one by one. The bench drives a full-range random 16-bit timer value in every machine cycle, so a wrong bit slice or a capture taken one strobe off shows up as a mismatch. The two-stage synchroniser leaves room in a six-clock machine cycle for pin pulses that are gone before the next strobe.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_mode_e;

  function automatic logic edge_hit(edge_mode_e mode, logic old_l, logic new_l);
    unique case (mode)
      EDGE_RISE: edge_hit = ~old_l & new_l;
      EDGE_FALL: edge_hit = old_l & ~new_l;
      EDGE_ANY:  edge_hit = old_l ^ new_l;
      default:   edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det
  import cap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       phase_i,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  output logic       pend_o
);
  logic smp_q, pend_q;

  // sample and compare only at the cycle strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (phase_i) begin
      smp_q  <= lvl_i;
      pend_q <= edge_hit(edge_mode_e'(mode_i), smp_q, lvl_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/cap_chan.sv
module cap_chan #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          phase_i,
  input  logic          pend_i,
  input  logic          clr_i,
  input  logic [TW-1:0] timer_i,
  output logic [TW-1:0] cap_o,
  output logic          flag_o
);
  logic          take;
  logic [TW-1:0] cap_q;
  logic          flag_q;

  // a pending edge lands at the strobe closing its machine cycle
  assign take = phase_i & pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (take) cap_q <= timer_i;
      flag_q <= take | (flag_q & ~clr_i);
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cap_unit4.sv
module cap_unit4 #(
  parameter int N_CH        = 4,
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_i,
  input  logic [TW-1:0]      timer_i,
  input  logic [N_CH-1:0]    cap_pin_i,
  input  logic [2*N_CH-1:0]  edge_sel_i,
  input  logic [N_CH-1:0]    flag_clr_i,
  output logic [N_CH*TW-1:0] cap_o,
  output logic [N_CH-1:0]    flag_o
);
  localparam int MW = 2;

  logic [N_CH-1:0] lvl_w;
  logic [N_CH-1:0] pend_w;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (cap_pin_i[i]),
      .q_o   (lvl_w[i])
    );

    cap_edge_det u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .phase_i(phase_i),
      .lvl_i  (lvl_w[i]),
      .mode_i (edge_sel_i[MW*i +: MW]),
      .pend_o (pend_w[i])
    );

    cap_chan #(.TW(TW)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .phase_i(phase_i),
      .pend_i (pend_w[i]),
      .clr_i  (flag_clr_i[i]),
      .timer_i(timer_i),
      .cap_o  (cap_o[TW*i +: TW]),
      .flag_o (flag_o[i])
    );
  end
endmodule

// File: rtl/cap_unit4_chk.sv
module cap_unit4_chk #(
  parameter int N_CH = 4,
  parameter int TW   = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               phase_i,
  input logic [N_CH-1:0]    flag_clr_i,
  input logic [N_CH*TW-1:0] cap_o,
  input logic [N_CH-1:0]    flag_o,
  input logic [N_CH-1:0]    pend_i
);
  for (genvar i = 0; i < N_CH; i++) begin : g_a
    // R6: register moves only on a strobe clock
    a_r6_cap_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(phase_i) |-> $stable(cap_o[TW*i +: TW]));
    // R6: flag rises only on a strobe clock
    a_r6_flag_on_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_o[i]) |-> $past(phase_i));
    // R7: flag drops only after a clear request
    a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_o[i]) |-> $past(flag_clr_i[i]));
    // R8: a landing capture leaves the flag set despite a clear
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(phase_i) && $past(pend_i[i])) |-> flag_o[i]);
    // R6: a changed register always comes with its flag
    a_r6_cap_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(cap_o[TW*i +: TW]) |-> flag_o[i]);
  end
endmodule

bind cap_unit4 cap_unit4_chk #(.N_CH(N_CH), .TW(TW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phase_i   (phase_i),
  .flag_clr_i(flag_clr_i),
  .cap_o     (cap_o),
  .flag_o    (flag_o),
  .pend_i    (pend_w)
);

// File: tb/cap_unit4_test.sv
module cap_unit4_test;
  localparam int N  = 4;
  localparam int TW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            phase = 1'b0;
  logic [TW-1:0]   timer = '0;
  logic [N-1:0]    pins = '0;
  logic [2*N-1:0]  sel = '0;
  logic [N-1:0]    clr = '0;
  logic [N*TW-1:0] cap;
  logic [N-1:0]    flag;

  int n_chk = 0;
  int n_bad = 0;

  logic          m_smp [N];
  logic          m_pend[N];
  logic          m_flag[N];
  logic [TW-1:0] m_cap [N];

  always #2 clk = ~clk;

  cap_unit4 #(.N_CH(N), .TW(TW), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(phase), .timer_i(timer),
    .cap_pin_i(pins), .edge_sel_i(sel), .flag_clr_i(clr),
    .cap_o(cap), .flag_o(flag)
  );

  function automatic logic want_edge(logic [1:0] m, logic a, logic b);
    if (m == 2'b01) return (a == 1'b0) && (b == 1'b1);
    if (m == 2'b10) return (a == 1'b1) && (b == 1'b0);
    if (m == 2'b11) return a != b;
    return 1'b0;
  endfunction

  task automatic model_edge();
    for (int c = 0; c < N; c++) begin
      logic landed;
      landed = phase && m_pend[c];
      if (phase) begin
        m_pend[c] = want_edge(sel[2*c +: 2], m_smp[c], pins[c]);
        m_smp[c]  = pins[c];
      end
      if (landed) begin
        m_cap[c]  = timer;
        m_flag[c] = 1'b1;
      end else if (clr[c]) begin
        m_flag[c] = 1'b0;
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int c = 0; c < N; c++) begin
      n_chk++;
      if (cap[TW*c +: TW] !== m_cap[c]) begin
        n_bad++;
        $display("FAIL %s ch%0d cap actual %h expected %h", tag, c, cap[TW*c +: TW], m_cap[c]);
      end
      n_chk++;
      if (flag[c] !== m_flag[c]) begin
        n_bad++;
        $display("FAIL %s ch%0d flag actual %b expected %b", tag, c, flag[c], m_flag[c]);
      end
    end
  endtask

  // one six-clock machine cycle; outputs compared at clock 4
  task automatic run_cycle(input logic [N-1:0] p_new, input logic pulse,
                           input logic [2*N-1:0] s_new, input logic [N-1:0] c0,
                           input logic [N-1:0] c3, input string tag);
    logic [N-1:0] keep;
    phase = 1'b1; timer = TW'($urandom); clr = c0;
    tick();
    phase = 1'b0; clr = '0; sel = s_new; keep = pins;
    pins = pulse ? ~pins : p_new;
    tick();
    if (pulse) pins = keep;
    tick();
    clr = c3;
    tick();
    clr = '0;
    check_all(tag);
    tick();
    tick();
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    for (int c = 0; c < N; c++) begin
      m_smp[c] = 0; m_pend[c] = 0; m_flag[c] = 0; m_cap[c] = '0;
    end
    repeat (3) @(negedge clk);
    check_all("R10");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 rising only
    run_cycle(4'b0000, 0, 8'h55, '0, '0, "R2");
    run_cycle(4'b0101, 0, 8'h55, '0, '0, "R2");
    run_cycle(4'b1111, 0, 8'h55, '0, '0, "R2");
    run_cycle(4'b0000, 0, 8'h55, '0, '0, "R2");
    run_cycle(4'b0000, 0, 8'h55, '0, '0, "R6");
    run_cycle(4'b0000, 0, 8'h55, '0, '0, "R7");
    run_cycle(4'b0000, 0, 8'h55, '0, 4'hf, "R11");
    // R3 falling only
    run_cycle(4'b1111, 0, 8'haa, '0, '0, "R3");
    run_cycle(4'b0011, 0, 8'haa, '0, '0, "R3");
    run_cycle(4'b0000, 0, 8'haa, '0, '0, "R3");
    run_cycle(4'b0000, 0, 8'haa, '0, '0, "R3");
    run_cycle(4'b0000, 0, 8'haa, '0, 4'hf, "R11");
    // R4 both edges
    run_cycle(4'b1010, 0, 8'hff, '0, '0, "R4");
    run_cycle(4'b0101, 0, 8'hff, '0, '0, "R4");
    run_cycle(4'b0101, 0, 8'hff, '0, '0, "R4");
    // R8 clear at the strobe where captures land
    run_cycle(4'b1010, 0, 8'hff, 4'hf, '0, "R4");
    run_cycle(4'b1010, 0, 8'hff, 4'hf, '0, "R8");
    run_cycle(4'b1010, 0, 8'hff, 4'hf, '0, "R8");
    // R1 short pulses between strobes
    run_cycle(4'b1010, 1, 8'hff, '0, '0, "R1");
    run_cycle(4'b1010, 1, 8'hff, '0, '0, "R1");
    run_cycle(4'b1010, 0, 8'hff, '0, '0, "R1");
    // R5 channels off
    run_cycle(4'b1010, 0, 8'h00, '0, 4'hf, "R5");
    run_cycle(4'b0101, 0, 8'h00, '0, '0, "R5");
    run_cycle(4'b1010, 0, 8'h00, '0, '0, "R5");
    run_cycle(4'b1010, 0, 8'h00, '0, '0, "R5");
    // R9 single-channel events
    for (int k = 0; k < N; k++) begin
      run_cycle(pins ^ (4'b1 << k), 0, 8'hff, '0, '0, "R9");
      run_cycle(pins, 0, 8'hff, '0, '0, "R9");
      run_cycle(pins, 0, 8'hff, '0, 4'hf, "R9");
    end
    // random mix
    for (int k = 0; k < 300; k++) begin
      logic [2*N-1:0] s;
      s = ($urandom % 8 == 0) ? (2*N)'($urandom) : sel;
      run_cycle(N'($urandom), ($urandom % 6 == 0), s,
                ($urandom % 4 == 0) ? N'($urandom) : '0,
                ($urandom % 4 == 0) ? N'($urandom) : '0, "R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule